// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Status Flags

This block is the combinational arithmetic/logic unit of a small 8-bit core. It takes two operands and a 3-bit operation select. It returns an 8-bit result and three status flags: carry, half-carry (the nibble carry) and zero. It has no clock and no storage. The surrounding core decides when to capture the result and the flags.

The eight operations are addition, subtraction, AND, OR, complement, a one-place logical shift left, a one-place logical shift right, and an exchange of the two nibbles. The four single-operand operations read operand A only, and operand B has no effect on them. Every operation drives all three flags. Operations that produce no carry or borrow drive carry and half-carry to 0.

Top module: `alu8_core`

## Requirements
- R1: Select 000 gives result = (A + B) mod 256.
- R2: For select 000, carry is the carry out of bit 7 and half-carry is the carry out of bit 3 (the sum of the low nibbles exceeds 15).
- R3: Select 001 gives result = (A - B) mod 256. Carry is 1 when A < B, and half-carry is 1 when A[3:0] < B[3:0] (borrows out of bit 7 and bit 3).
- R4: Select 010 gives A AND B and select 011 gives A OR B. Both drive carry and half-carry to 0.
- R5: Select 100 gives the bitwise complement of A. Carry and half-carry are 0, and B has no effect.
- R6: Select 101 gives {A[6:0], 0}. Carry = A[7], half-carry = 0, and B has no effect.
- R7: Select 110 gives {0, A[7:1]}. Carry = A[0], half-carry = 0, and B has no effect.
- R8: Select 111 gives {A[3:0], A[7:4]}. Carry and half-carry are 0, and B has no effect.
- R9: For every select value, zero is 1 exactly when the 8-bit result is 0x00.
- R10: The outputs depend only on the present inputs. A change of any input shows on the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand; the only source for the single-operand operations |
| opnd_b | input | 8 | Second operand |
| op_sel | input | 3 | Operation select, encoded as listed in R1 to R8 |
| result | output | 8 | Operation result |
| carry_o | output | 1 | Carry, borrow or shifted-out bit |
| half_o | output | 1 | Carry or borrow out of bit 3 |
| zero_o | output | 1 | High when result is zero |

## Verification
The bound checker evaluates relations between the ports whenever an input moves. It checks the zero flag against the result for every select value. For the operations without a carry, it checks that carry and half-carry are cleared. It checks the fill bit of each shift and the nibble exchange of the swap. Whether the add and subtract results and their carries and borrows are correct, whether operand B has no effect on the single-operand operations, and whether the outputs follow input changes made between clock edges are shown only by the bench's scenarios. The bench compares those scenarios against its own behavioural model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_NOT  = 3'b100,
        OP_SHL  = 3'b101,
        OP_SHR  = 3'b110,
        OP_SWAP = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic hc;
    } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    input  logic               sub_i,
    output logic [W-1:0]       res_o,
    output alu8_pkg::alu_flags_t flg_o
);
    localparam int NIB = W / 2;

    logic [W:0]   full_d;
    logic [NIB:0] low_d;

    always_comb begin
        if (sub_i) begin
            full_d = {1'b0, a_i} - {1'b0, b_i};
            low_d  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]};
        end else begin
            full_d = {1'b0, a_i} + {1'b0, b_i};
            low_d  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]};
        end
        res_o     = full_d[W-1:0];
        flg_o.cy  = full_d[W];
        flg_o.hc  = low_d[NIB];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   fn_i,
    output logic [W-1:0] res_o
);
    localparam int NIB = W / 2;

    logic [W-1:0] swp_d;

    for (genvar i = 0; i < NIB; i++) begin : g_swap
        assign swp_d[i]       = a_i[i + NIB];
        assign swp_d[i + NIB] = a_i[i];
    end

    always_comb begin
        unique case (fn_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i | b_i;
            2'd2:    res_o = ~a_i;
            default: res_o = swp_d;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         right_i,
    output logic [W-1:0] res_o,
    output logic         out_bit_o
);
    always_comb begin
        if (right_i) begin
            res_o     = {1'b0, a_i[W-1:1]};
            out_bit_o = a_i[0];
        end else begin
            res_o     = {a_i[W-2:0], 1'b0};
            out_bit_o = a_i[W-1];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_o,
    output logic         half_o,
    output logic         zero_o
);
    import alu8_pkg::*;

    typedef struct packed {
        logic [W-1:0] val;
        alu_flags_t   flg;
    } out_t;

    logic [W-1:0] arith_res, logic_res, shift_res;
    alu_flags_t   arith_flg;
    logic         shift_bit;
    out_t         out_d;

    alu8_arith #(.W(W)) u_arith (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .sub_i (op_sel == OP_SUB),
        .res_o (arith_res),
        .flg_o (arith_flg)
    );

    alu8_logic #(.W(W)) u_logic (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .fn_i  ({op_sel[2], op_sel[0]}),
        .res_o (logic_res)
    );

    alu8_shift #(.W(W)) u_shift (
        .a_i       (opnd_a),
        .right_i   (op_sel == OP_SHR),
        .res_o     (shift_res),
        .out_bit_o (shift_bit)
    );

    always_comb begin
        out_d = '0;
        unique case (alu_op_e'(op_sel))
            OP_ADD, OP_SUB: begin
                out_d.val = arith_res;
                out_d.flg = arith_flg;
            end
            OP_SHL, OP_SHR: begin
                out_d.val    = shift_res;
                out_d.flg.cy = shift_bit;
            end
            default: out_d.val = logic_res;
        endcase
    end

    assign result  = out_d.val;
    assign carry_o = out_d.flg.cy;
    assign half_o  = out_d.flg.hc;
    assign zero_o  = (out_d.val == '0);
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry_o,
    input logic         half_o,
    input logic         zero_o
);
    localparam int NIB = W / 2;

    always_comb begin
        p_zero_flag_r9: assert (zero_o == (result == '0))
            else $error("zero flag disagrees with result");
        if (op_sel == 3'b010 || op_sel == 3'b011) begin
            p_logic_noflags_r4: assert (!carry_o && !half_o)
                else $error("AND/OR flags set");
        end
        if (op_sel == 3'b100) begin
            p_not_noflags_r5: assert (!carry_o && !half_o && ((result ^ opnd_a) == '1))
                else $error("complement wrong");
        end
        if (op_sel == 3'b101) begin
            p_shl_fill_r6: assert (!result[0] && !half_o && carry_o == opnd_a[W-1])
                else $error("left shift wrong");
        end
        if (op_sel == 3'b110) begin
            p_shr_fill_r7: assert (!result[W-1] && !half_o && carry_o == opnd_a[0])
                else $error("right shift wrong");
        end
        if (op_sel == 3'b111) begin
            p_swap_halves_r8: assert (!carry_o && !half_o &&
                                      result[W-1:NIB] == opnd_a[NIB-1:0] &&
                                      result[NIB-1:0] == opnd_a[W-1:NIB])
                else $error("swap wrong");
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_sel  (op_sel),
    .result  (result),
    .carry_o (carry_o),
    .half_o  (half_o),
    .zero_o  (zero_o)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [2:0] op_sel = '0;
    logic [7:0] result;
    logic       carry_o, half_o, zero_o;
    int         n_chk = 0, n_fail = 0, cyc = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core u0 (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
        .result(result), .carry_o(carry_o), .half_o(half_o), .zero_o(zero_o)
    );

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1/R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input int a, input int b, input int op, input string extra);
        int res, c, h, z;
        c = 0; h = 0;
        case (op)
            0: begin res = (a + b) % 256; c = (a + b) / 256; h = ((a % 16) + (b % 16)) / 16; end
            1: begin res = (a - b + 256) % 256; c = (a < b); h = ((a % 16) < (b % 16)); end
            2: res = a & b;
            3: res = a | b;
            4: res = 255 - a;
            5: begin res = (a * 2) % 256; c = a / 128; end
            6: begin res = a / 2; c = a % 2; end
            default: res = (a % 16) * 16 + a / 16;
        endcase
        z = (res == 0);
        n_chk++;
        if (int'(result) != res || int'(carry_o) != c || int'(half_o) != h) begin
            n_fail++;
            $display("FAIL %s%s op=%0d a=%0d b=%0d: got res=%0d c=%0d h=%0d, expected res=%0d c=%0d h=%0d",
                     tag_of(op), extra, op, a, b, result, carry_o, half_o, res, c, h);
        end
        n_chk++;
        if (int'(zero_o) != z) begin
            n_fail++;
            $display("FAIL R9 op=%0d a=%0d b=%0d: got zero=%0d, expected %0d", op, a, b, zero_o, z);
        end
    endtask

    task automatic apply(input int a, input int b, input int op);
        @(posedge clk);
        opnd_a = 8'(a); opnd_b = 8'(b); op_sel = 3'(op);
        @(negedge clk);
        compare(a, b, op, "");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        #1;
        // Reset state: all-zero inputs select add of zeros
        n_chk++;
        if (result !== 8'h00 || carry_o !== 1'b0 || half_o !== 1'b0 || zero_o !== 1'b1) begin
            n_fail++;
            $display("FAIL R1/R9 initial: got res=%0d c=%0d h=%0d z=%0d, expected 0 0 0 1",
                     result, carry_o, half_o, zero_o);
        end
        // Directed corner cases for R1 R2 R3
        apply(8'hFF, 8'h01, 0);   // wrap, both carries
        apply(8'h0F, 8'h01, 0);   // half carry only
        apply(8'h80, 8'h80, 0);   // carry, zero result
        apply(8'h00, 8'h01, 1);   // borrow both
        apply(8'h10, 8'h01, 1);   // half borrow only
        apply(8'h55, 8'h55, 1);   // zero, no borrow
        // R4 R5 R6 R7 R8 corners
        apply(8'hF0, 8'h0F, 2);
        apply(8'h00, 8'h00, 3);
        apply(8'hFF, 8'h12, 4);
        apply(8'h80, 8'hFF, 5);
        apply(8'h01, 8'hFF, 6);
        apply(8'h00, 8'hAA, 7);
        apply(8'hA5, 8'h3C, 7);
        // Operand B ignored for single-operand ops (R5 R6 R7 R8)
        for (int op = 4; op < 8; op++) begin
            for (int b = 0; b < 256; b += 17) apply(8'h6B, b, op);
        end
        // Pseudo-random sweep over every select
        lfsr = 8'h5A;
        for (int i = 0; i < 1200; i++) begin
            int a, b;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            a = int'(lfsr);
            b = (a * 37 + i) % 256;
            apply(a, b, i % 8);
        end
        // R10: inputs changed between edges show with no clock
        for (int op = 0; op < 8; op++) begin
            @(negedge clk);
            #0.5;
            opnd_a = 8'h3E; opnd_b = 8'hC3; op_sel = 3'(op);
            #0.5;
            compare(8'h3E, 8'hC3, op, " R10");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule